// File: doc/BRIEF.md
# Shared Buffer Address Manager

This block owns the addresses of a packet buffer that every port of a multi-port switch shares. It keeps the unused addresses in a free pool. It hands the address at the head of the pool to whichever input controller asks for one. For every address it keeps an occupancy counter. When an input controller commits a granted address, the counter is loaded with the number of outputs the packet is destined for.

Each transmission report from an output controller lowers that address's counter by one. The report that brings the counter to zero also puts the address back at the tail of the pool. A multicast packet therefore holds its buffer slot until its last copy has left.

The block watches for two corruption cases: loading a counter that is still in use, and reporting a transmission against a counter that is already zero. Either case sets a sticky status bit. That bit drives the interrupt output unless the interrupt is masked.

Top module: `buf_addr_mgr`

## Requirements
- R1: After reset, `grant_valid` is 1, `grant_addr` is 0, and `corrupt_status` and `irq` are 0.
- R2: The pool starts holding every address in ascending order. Each cycle with `alloc_req` and `grant_valid` both high removes the head, so the next cycle presents the next address.
- R3: When the pool holds no address, `grant_valid` is 0 and `alloc_req` has no effect. A release in such a cycle makes `grant_valid` 1 from the next cycle.
- R4: A commit of an address whose counter is zero loads the counter with `commit_dests`. That address is released only by the transmission report that brings the counter to exactly zero, so it takes `commit_dests` reports.
- R5: Released addresses join the tail of the pool. They are granted in the order of release, after every address that was already in the pool.
- R6: A commit to an address whose counter is non-zero sets `corrupt_status` at the next clock edge and leaves the counter unchanged.
- R7: A transmission report for an address whose counter is zero sets `corrupt_status` at the next clock edge and changes neither the counter nor the pool.
- R8: `irq` is 1 exactly when `corrupt_status` is 1 and `irq_mask` is 0. The mask never stops `corrupt_status` from being set.
- R9: When a commit and a transmission report name the same address in one cycle, the commit is applied first. With `commit_dests` = 1 and a zero counter, the address is released in that same cycle.
- R10: `corrupt_clr` clears `corrupt_status` at the next edge. A corruption event in the same cycle takes precedence and keeps the bit set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| alloc_req | input | 1 | Input controller takes the presented address this cycle |
| grant_valid | output | 1 | Pool is non-empty; `grant_addr` is valid |
| grant_addr | output | ADDR_W | Address at the head of the free pool |
| commit_valid | input | 1 | Load an occupancy counter |
| commit_addr | input | ADDR_W | Address being committed |
| commit_dests | input | CNT_W | Number of destinations of the stored packet |
| tx_valid | input | 1 | Output controller reports one transmission |
| tx_addr | input | ADDR_W | Address of the transmitted packet |
| irq_mask | input | 1 | 1 masks the corruption interrupt |
| corrupt_clr | input | 1 | Clears the corruption status bit |
| corrupt_status | output | 1 | Sticky address-corruption status |
| irq | output | 1 | Main interrupt |

## Verification
The case hardest to reach from the ports is a release, or a same-cycle commit and release of one address, while the pool is completely empty. It also needs to be followed by grants in release order. The stimulus drains all sixteen preloaded addresses with back-to-back requests. It then releases and recycles addresses while the pool is empty, with directed commit and report collisions. A long seeded random phase follows that mixes legal traffic with occasional deliberate corruption, mask changes and clears, all compared against a bench model of the pool and counters.

// File: rtl/bam_pkg.sv
// Package: shared types and default sizes for the buffer address manager.
// Assumes: nothing; included first in compile order.
package bam_pkg;
    // Default width of a buffer address (16 addresses)
    parameter int BAM_ADDR_W_DEF = 4;
    // Default width of an occupancy counter (up to 7 destinations)
    parameter int BAM_CNT_W_DEF  = 3;

    // One flag per kind of address corruption detected in a cycle
    typedef struct packed {
        logic load_busy;   // counter loaded while non-zero
        logic free_idle;   // transmission reported on a zero counter
    } corrupt_evt_t;
endpackage

// File: rtl/bam_free_pool.sv
// Module: bam_free_pool
// FIFO of free buffer addresses. Reset preloads every address in ascending
// order, so the FIFO starts full. Assumes the caller never pushes an address
// that is already stored, so the FIFO can never hold more than DEPTH entries.
module bam_free_pool #(
    parameter int ADDR_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              pop,
    input  logic              push,
    input  logic [ADDR_W-1:0] push_addr,
    output logic [ADDR_W-1:0] head_addr,
    output logic              not_empty,
    output logic [ADDR_W:0]   level
);
    localparam int DEPTH = 1 << ADDR_W;

    logic [ADDR_W-1:0] slots [DEPTH];
    logic [ADDR_W-1:0] rd_ptr;
    logic [ADDR_W-1:0] wr_ptr;
    logic              pop_ok;

    // A pop only takes effect when an address is present
    always_comb begin
        not_empty = (level != '0);
        pop_ok    = pop && not_empty;
        head_addr = slots[rd_ptr];
    end

    // Slot storage: preload ascending addresses, then write releases at the tail
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) begin
                slots[i] <= ADDR_W'(i);
            end
        end else if (push) begin
            slots[wr_ptr] <= push_addr;
        end
    end

    // Pointers and fill level
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_ptr <= '0;
            wr_ptr <= '0;
            level  <= (ADDR_W+1)'(DEPTH);
        end else begin
            if (push) begin
                wr_ptr <= wr_ptr + 1'b1;
            end
            if (pop_ok) begin
                rd_ptr <= rd_ptr + 1'b1;
            end
            level <= level + (ADDR_W+1)'(push) - (ADDR_W+1)'(pop_ok);
        end
    end
endmodule

// File: rtl/bam_occupancy.sv
// Module: bam_occupancy
// One occupancy counter per buffer address. A commit loads a counter and a
// transmission report decrements one. A decrement that reaches zero emits a
// release. If both operations name the same address in a cycle, the load is
// applied first. An erroneous operation leaves its counter unchanged and
// raises a corruption flag. Assumes at most one commit and one report per cycle.
module bam_occupancy
    import bam_pkg::*;
#(
    parameter int ADDR_W = 4,
    parameter int CNT_W  = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ld_valid,
    input  logic [ADDR_W-1:0] ld_addr,
    input  logic [CNT_W-1:0]  ld_count,
    input  logic              dec_valid,
    input  logic [ADDR_W-1:0] dec_addr,
    output logic              rel_valid,
    output logic [ADDR_W-1:0] rel_addr,
    output corrupt_evt_t      evt
);
    localparam int NUM_ADDR = 1 << ADDR_W;

    logic [CNT_W-1:0] occ [NUM_ADDR];
    logic             ld_ok;
    logic [CNT_W-1:0] dec_view;

    // Classify this cycle's operations; the decrement sees the value after the load
    always_comb begin
        ld_ok         = ld_valid && (occ[ld_addr] == '0);
        dec_view      = (ld_ok && (ld_addr == dec_addr)) ? ld_count : occ[dec_addr];
        evt.load_busy = ld_valid && !ld_ok;
        evt.free_idle = dec_valid && (dec_view == '0);
        rel_valid     = dec_valid && (dec_view == CNT_W'(1));
        rel_addr      = dec_addr;
    end

    for (genvar g = 0; g < NUM_ADDR; g++) begin : g_cnt
        logic [CNT_W-1:0] after_ld;
        logic [CNT_W-1:0] nxt;

        // Next value of this entry: load first, then decrement if non-zero
        always_comb begin
            after_ld = occ[g];
            if (ld_valid && (ld_addr == ADDR_W'(g)) && (occ[g] == '0)) begin
                after_ld = ld_count;
            end
            nxt = after_ld;
            if (dec_valid && (dec_addr == ADDR_W'(g)) && (after_ld != '0)) begin
                nxt = after_ld - 1'b1;
            end
        end

        // Counter register for this entry
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                occ[g] <= '0;
            end else begin
                occ[g] <= nxt;
            end
        end
    end
endmodule

// File: rtl/bam_corrupt_irq.sv
// Module: bam_corrupt_irq
// Sticky address-corruption status bit and its maskable interrupt output.
// A new event takes precedence over a clear in the same cycle.
module bam_corrupt_irq
    import bam_pkg::*;
(
    input  logic         clk,
    input  logic         rst_n,
    input  corrupt_evt_t evt,
    input  logic         clr,
    input  logic         mask,
    output logic         status,
    output logic         irq
);
    // Set on any event, otherwise clear on request
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            status <= 1'b0;
        end else if (evt.load_busy || evt.free_idle) begin
            status <= 1'b1;
        end else if (clr) begin
            status <= 1'b0;
        end
    end

    // Interrupt follows the status bit unless it is masked
    always_comb begin
        irq = status && !mask;
    end
endmodule

// File: rtl/buf_addr_mgr.sv
// Module: buf_addr_mgr (top)
// Shared buffer address manager. It grants free addresses from a FIFO pool,
// tracks multicast occupancy per address, recycles an address when its last
// copy is transmitted, and flags address corruption.
// Assumes input controllers commit only addresses they were granted.
module buf_addr_mgr
    import bam_pkg::*;
#(
    parameter int ADDR_W = BAM_ADDR_W_DEF,
    parameter int CNT_W  = BAM_CNT_W_DEF
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              alloc_req,
    output logic              grant_valid,
    output logic [ADDR_W-1:0] grant_addr,
    input  logic              commit_valid,
    input  logic [ADDR_W-1:0] commit_addr,
    input  logic [CNT_W-1:0]  commit_dests,
    input  logic              tx_valid,
    input  logic [ADDR_W-1:0] tx_addr,
    input  logic              irq_mask,
    input  logic              corrupt_clr,
    output logic              corrupt_status,
    output logic              irq
);
    logic              rel_valid;
    logic [ADDR_W-1:0] rel_addr;
    logic [ADDR_W:0]   pool_level;
    corrupt_evt_t      evt;

    bam_free_pool #(.ADDR_W(ADDR_W)) u_pool (
        .clk       (clk),
        .rst_n     (rst_n),
        .pop       (alloc_req),
        .push      (rel_valid),
        .push_addr (rel_addr),
        .head_addr (grant_addr),
        .not_empty (grant_valid),
        .level     (pool_level)
    );

    bam_occupancy #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) u_occ (
        .clk       (clk),
        .rst_n     (rst_n),
        .ld_valid  (commit_valid),
        .ld_addr   (commit_addr),
        .ld_count  (commit_dests),
        .dec_valid (tx_valid),
        .dec_addr  (tx_addr),
        .rel_valid (rel_valid),
        .rel_addr  (rel_addr),
        .evt       (evt)
    );

    bam_corrupt_irq u_irq (
        .clk    (clk),
        .rst_n  (rst_n),
        .evt    (evt),
        .clr    (corrupt_clr),
        .mask   (irq_mask),
        .status (corrupt_status),
        .irq    (irq)
    );
endmodule

// File: rtl/buf_addr_mgr_chk.sv
// Module: buf_addr_mgr_chk
// Property checker for buf_addr_mgr, attached with the bind below.
module buf_addr_mgr_chk
    import bam_pkg::*;
#(
    parameter int ADDR_W = 4
) (
    input logic              clk,
    input logic              rst_n,
    input logic              alloc_req,
    input logic              grant_valid,
    input logic [ADDR_W-1:0] grant_addr,
    input logic              tx_valid,
    input logic              irq_mask,
    input logic              corrupt_clr,
    input logic              corrupt_status,
    input logic              irq,
    input logic              rel_valid,
    input logic [ADDR_W:0]   pool_level,
    input corrupt_evt_t      evt
);
    localparam int NUM_ADDR = 1 << ADDR_W;

    AST_EMPTY_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (!grant_valid && !tx_valid) |=> !grant_valid);                     // R3
    AST_IDLE_HEAD_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
        (grant_valid && !alloc_req && !rel_valid) |=> (grant_valid && $stable(grant_addr))); // R2
    AST_POOL_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        pool_level <= (ADDR_W+1)'(NUM_ADDR));                              // R5
    AST_ERR_RELEASE_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
        !(evt.free_idle && rel_valid));                                    // R7
    AST_CORRUPT_SETS: assert property (@(posedge clk) disable iff (!rst_n)
        (evt.load_busy || evt.free_idle) |=> corrupt_status);              // R6
    AST_MASK_SILENCES: assert property (@(posedge clk) disable iff (!rst_n)
        irq_mask |-> !irq);                                                // R8
    AST_CLEAR_WORKS: assert property (@(posedge clk) disable iff (!rst_n)
        (corrupt_clr && !evt.load_busy && !evt.free_idle) |=> !corrupt_status); // R10
endmodule

bind buf_addr_mgr buf_addr_mgr_chk #(.ADDR_W(ADDR_W)) i_chk (
    .clk            (clk),
    .rst_n          (rst_n),
    .alloc_req      (alloc_req),
    .grant_valid    (grant_valid),
    .grant_addr     (grant_addr),
    .tx_valid       (tx_valid),
    .irq_mask       (irq_mask),
    .corrupt_clr    (corrupt_clr),
    .corrupt_status (corrupt_status),
    .irq            (irq),
    .rel_valid      (rel_valid),
    .pool_level     (pool_level),
    .evt            (evt)
);

// File: tb/test_buf_addr_mgr.sv
// Bench for buf_addr_mgr: directed corner cases, then seeded random traffic,
// all compared against a reference model of the pool and counters.
module test_buf_addr_mgr;
    localparam int AW = 4;
    localparam int CW = 3;
    localparam int NA = 1 << AW;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          alloc_req = 1'b0;
    logic          grant_valid;
    logic [AW-1:0] grant_addr;
    logic          commit_valid = 1'b0;
    logic [AW-1:0] commit_addr = '0;
    logic [CW-1:0] commit_dests = '0;
    logic          tx_valid = 1'b0;
    logic [AW-1:0] tx_addr = '0;
    logic          irq_mask = 1'b0;
    logic          corrupt_clr = 1'b0;
    logic          corrupt_status;
    logic          irq;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 0;

    // reference model
    int fq[$];
    int held[$];
    int cm[NA];
    bit st = 0;

    always #10 clk = ~clk;

    buf_addr_mgr #(.ADDR_W(AW), .CNT_W(CW)) i_buf_addr_mgr (.*);

    task automatic expect_eq(string tag, string what, int act, int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
        end
    endtask

    task automatic check(string tag);
        int gv = (fq.size() > 0) ? 1 : 0;
        expect_eq(tag, "grant_valid", int'(grant_valid), gv);
        if (gv == 1) expect_eq(tag, "grant_addr", int'(grant_addr), fq[0]);
        expect_eq(tag, "corrupt_status", int'(corrupt_status), int'(st));
        expect_eq(tag, "irq", int'(irq), int'(st && !irq_mask));
    endtask

    // One cycle: drive at negedge, update model at edge, check at next negedge
    task automatic cyc(string tag, bit a, bit c, int ca, int cc, bit t, int ta, bit clr);
        bit pop;
        bit push = 0;
        bit err = 0;
        alloc_req = a; commit_valid = c; commit_addr = AW'(ca); commit_dests = CW'(cc);
        tx_valid = t; tx_addr = AW'(ta); corrupt_clr = clr;
        @(posedge clk);
        pop = a && (fq.size() > 0);
        if (c) begin
            if (cm[ca] != 0) err = 1;
            else begin
                cm[ca] = cc;
                foreach (held[k]) if (held[k] == ca) begin held.delete(k); break; end
            end
        end
        if (t) begin
            if (cm[ta] == 0) err = 1;
            else begin
                cm[ta]--;
                if (cm[ta] == 0) push = 1;
            end
        end
        if (pop) held.push_back(fq.pop_front());
        if (push) fq.push_back(ta);
        if (err) st = 1; else if (clr) st = 0;
        @(negedge clk);
        alloc_req = 0; commit_valid = 0; tx_valid = 0; corrupt_clr = 0;
        check(tag);
    endtask

    initial begin
        repeat (2000) @(posedge clk);
        for (int i = 0; i < 200; i++) begin
            if (done) break;
            repeat (1000) @(posedge clk);
        end
        if (!done) begin
            n_fail++;
            n_chk++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin
        int dummy;
        dummy = $urandom(32'd20240611);
        for (int i = 0; i < NA; i++) begin fq.push_back(i); cm[i] = 0; end
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        check("R1");
        // R2 drain in ascending order
        for (int i = 0; i < NA; i++) cyc("R2", 1, 0, 0, 0, 0, 0, 0);
        // R3 request while empty has no effect
        cyc("R3", 1, 0, 0, 0, 0, 0, 0);
        cyc("R3", 1, 0, 0, 0, 0, 0, 0);
        // R4 two destinations need two reports
        cyc("R4", 0, 1, 3, 2, 0, 0, 0);
        cyc("R4", 0, 0, 0, 0, 1, 3, 0);
        cyc("R4", 0, 0, 0, 0, 1, 3, 0);
        // R3 release into empty pool, then R5 order of release
        cyc("R5", 0, 1, 5, 1, 0, 0, 0);
        cyc("R5", 0, 0, 0, 0, 1, 5, 0);
        // R9 same-cycle commit and report with one destination
        cyc("R9", 0, 1, 7, 1, 1, 7, 0);
        cyc("R5", 1, 0, 0, 0, 0, 0, 0);
        cyc("R5", 1, 0, 0, 0, 0, 0, 0);
        // R6 commit to a busy counter
        cyc("R6", 0, 1, 3, 2, 0, 0, 0);
        cyc("R6", 0, 1, 3, 5, 0, 0, 0);
        // R8 masking
        irq_mask = 1'b1;
        @(negedge clk); check("R8");
        irq_mask = 1'b0;
        @(negedge clk); check("R8");
        // R10 clear
        cyc("R10", 0, 0, 0, 0, 0, 0, 1);
        // R6 counter kept its value 2
        cyc("R6", 0, 0, 0, 0, 1, 3, 0);
        cyc("R6", 0, 0, 0, 0, 1, 3, 0);
        // R7 report on zero counter, clear in same cycle loses
        cyc("R7", 0, 0, 0, 0, 1, 3, 1);
        cyc("R7", 1, 0, 0, 0, 0, 0, 1);
        // random phase
        for (int n = 0; n < 4000; n++) begin
            bit a = ($urandom_range(0, 2) != 0);
            bit c = 0, t = 0, clr = ($urandom_range(0, 15) == 0);
            int ca = 0, cc = 1, ta = 0;
            int busy[$];
            int idle[$];
            for (int i = 0; i < NA; i++) if (cm[i] != 0) busy.push_back(i); else idle.push_back(i);
            if ($urandom_range(0, 29) == 0 && busy.size() > 0) begin
                c = 1; ca = busy[$urandom_range(0, busy.size() - 1)]; cc = $urandom_range(1, 7);
            end else if (held.size() > 0 && $urandom_range(0, 1) == 0) begin
                c = 1; ca = held[$urandom_range(0, held.size() - 1)]; cc = $urandom_range(1, 7);
            end
            if ($urandom_range(0, 29) == 0) begin
                t = 1; ta = idle[$urandom_range(0, idle.size() - 1)];
            end else if (busy.size() > 0 && $urandom_range(0, 3) != 0) begin
                t = 1; ta = busy[$urandom_range(0, busy.size() - 1)];
            end
            if ($urandom_range(0, 63) == 0) irq_mask = ~irq_mask;
            cyc("R4", a, c, ca, cc, t, ta, clr);
        end
        done = 1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule